// File: doc/BRIEF.md
# Link Rate and Lane Fallback Controller

This block sits above a link-training sequencer. When asked to start, it takes the rate and lane count that the sink advertises, limits them to what the system supports, and then runs a series of training attempts. Before each attempt it pulses a reset to the PHY and its drive levels, applies the sink's spread-spectrum choice, and waits a fixed settling time. It then triggers one training run and reads back whether clock recovery and equalization passed.

After a failed attempt the controller lowers the link capability. The phase that failed sets how it does this. A clock-recovery failure lowers the rate one step, and at the lowest rate it halves the lanes and returns to the starting rate. An equalization failure only reduces the lane count. The process stops with a pass flag when both phases succeed. It stops with a fail flag when the ladder runs out or when six attempts have been used. Rate codes follow the usual link-bandwidth encoding: 0x06, 0x0A, 0x14 and 0x1E, from lowest to highest.

Top module: `link_fallback_ctrl`

## Requirements
- R1: On `start`, `link_rate` loads the smaller of `cap_rate` and `sys_max_rate`, and `lane_cnt` loads the smaller of `cap_lane_field` and 4. Both are visible one cycle after the edge that samples `start`.
- R2: Every attempt begins with `phy_reset` high for exactly one cycle. SETTLE_CYCLES quiet cycles follow, then `train_go` is high for one cycle. `ssc_en` holds the `cap_ssc` value captured at `start`.
- R3: `link_rate` and `lane_cnt` stay unchanged while `busy` is high, except on the clock edge that samples `train_done`.
- R4: When clock recovery fails (`cr_ok`=0), the rate steps down 0x1E→0x14→0x0A→0x06 and the lane count is kept.
- R5: When clock recovery fails at rate 0x06, the lane count is halved (rounding down) and the rate goes back to the rate loaded at start. If the halved count is 0, the controller finishes with a fail.
- R6: When clock recovery fails at a rate outside {0x06, 0x0A, 0x14, 0x1E}, the controller finishes with a fail at once.
- R7: When clock recovery passes and equalization fails (`eq_ok`=0), the lane count goes from 4 to 2 or from 2 to 1. A count of 1 or 3 ends with a fail.
- R8: When `cr_ok` and `eq_ok` are both 1, the controller finishes with `done`=1 and `pass`=1, keeping the rate and lane count of that attempt.
- R9: No more than 6 attempts are made. If the sixth attempt fails, the controller finishes with a fail.
- R10: A fail sets `done`=1 and `pass`=0, drops `busy`, and leaves `link_rate` and `lane_cnt` at the values of the last attempt.
- R11: `start` has no effect while `busy` is high. When done or idle, `start` begins a new run.
- R12: Under reset, `busy`, `done`, `pass`, `phy_reset` and `train_go` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new fallback run |
| cap_rate | input | 8 | Sink's advertised rate code |
| cap_lane_field | input | 5 | Sink's advertised lane count field |
| sys_max_rate | input | 8 | Highest rate code the system allows |
| cap_ssc | input | 1 | Sink supports spread-spectrum |
| train_done | input | 1 | Training attempt finished; results valid |
| cr_ok | input | 1 | Clock recovery passed |
| eq_ok | input | 1 | Equalization passed |
| link_rate | output | 8 | Rate code for the current attempt |
| lane_cnt | output | 3 | Lane count for the current attempt |
| phy_reset | output | 1 | One-cycle PHY and drive-level reset |
| train_go | output | 1 | One-cycle trigger for the training run |
| ssc_en | output | 1 | Spread-spectrum enable for the PHY |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished; held until next start |
| pass | output | 1 | Finished run succeeded |

## Verification
Each run is driven from a chosen set of sink capabilities and a list of per-attempt results. A model in the bench predicts the rate and lane count of every attempt and checks them on every clock. Several result patterns are used, and each one isolates a different fallback path:
- Repeated clock-recovery failures from the top rate run through the whole rate ladder, the lane halving and the six-attempt budget.
- Equalization-only failures show that only the lane count changes.
- A lowest-rate, single-lane start and a code outside the ladder show the immediate-fail exits.
- A three-lane start shows that an odd lane count cannot fall back on equalization.
- A mixed run ends in a pass at reduced settings.
- A start pulse inside a run shows that `start` is ignored while busy.

// File: rtl/link_fallback_ctrl.sv
module link_fallback_ctrl #(
  parameter int RATE_W        = 8,
  parameter int LANE_W        = 3,
  parameter int MAX_LANES     = 4,
  parameter int MAX_TRIES     = 6,
  parameter int SETTLE_CYCLES = 16,
  parameter logic [RATE_W-1:0] RATE_L0 = 8'h06,
  parameter logic [RATE_W-1:0] RATE_L1 = 8'h0A,
  parameter logic [RATE_W-1:0] RATE_L2 = 8'h14,
  parameter logic [RATE_W-1:0] RATE_L3 = 8'h1E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [RATE_W-1:0] cap_rate,
  input  logic [4:0]        cap_lane_field,
  input  logic [RATE_W-1:0] sys_max_rate,
  input  logic              cap_ssc,
  input  logic              train_done,
  input  logic              cr_ok,
  input  logic              eq_ok,
  output logic [RATE_W-1:0] link_rate,
  output logic [LANE_W-1:0] lane_cnt,
  output logic              phy_reset,
  output logic              train_go,
  output logic              ssc_en,
  output logic              busy,
  output logic              done,
  output logic              pass
);
  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
  localparam int TRY_W = $clog2(MAX_TRIES + 1);

  typedef enum logic [2:0] {S_IDLE, S_RST, S_SETTLE, S_GO, S_WAIT, S_FIN} state_t;

  state_t            state;
  logic [CNT_W-1:0]  settle_cnt;
  logic [TRY_W-1:0]  tries;
  logic [RATE_W-1:0] top_rate;
  logic [RATE_W-1:0] nxt_rate;
  logic [LANE_W-1:0] nxt_lanes;
  logic              give_up;

  wire [RATE_W-1:0] start_rate  = (cap_rate < sys_max_rate) ? cap_rate : sys_max_rate;
  wire [LANE_W-1:0] start_lanes = (cap_lane_field >= 5'(MAX_LANES)) ? LANE_W'(MAX_LANES)
                                                                     : cap_lane_field[LANE_W-1:0];
  wire [LANE_W-1:0] half_lanes  = lane_cnt >> 1;

  assign phy_reset = (state == S_RST);
  assign train_go  = (state == S_GO);
  assign busy      = (state != S_IDLE) && (state != S_FIN);

  always_comb begin
    nxt_rate  = link_rate;
    nxt_lanes = lane_cnt;
    give_up   = 1'b0;
    if (!cr_ok) begin
      case (link_rate)
        RATE_L0: begin
          nxt_lanes = half_lanes;
          nxt_rate  = top_rate;
          give_up   = (half_lanes == '0);
        end
        RATE_L1: nxt_rate = RATE_L0;
        RATE_L2: nxt_rate = RATE_L1;
        RATE_L3: nxt_rate = RATE_L2;
        default: give_up = 1'b1;
      endcase
    end else if (!eq_ok) begin
      if (lane_cnt == LANE_W'(4))      nxt_lanes = LANE_W'(2);
      else if (lane_cnt == LANE_W'(2)) nxt_lanes = LANE_W'(1);
      else                             give_up = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      settle_cnt <= '0;
      tries      <= '0;
      top_rate   <= '0;
      link_rate  <= '0;
      lane_cnt   <= '0;
      ssc_en     <= 1'b0;
      done       <= 1'b0;
      pass       <= 1'b0;
    end else begin
      case (state)
        S_IDLE, S_FIN: begin
          if (start) begin
            link_rate <= start_rate;
            top_rate  <= start_rate;
            lane_cnt  <= start_lanes;
            ssc_en    <= cap_ssc;
            tries     <= '0;
            done      <= 1'b0;
            pass      <= 1'b0;
            state     <= S_RST;
          end
        end
        S_RST: begin
          settle_cnt <= '0;
          state      <= S_SETTLE;
        end
        S_SETTLE: begin
          if (settle_cnt == CNT_W'(SETTLE_CYCLES - 1)) state <= S_GO;
          else settle_cnt <= settle_cnt + 1'b1;
        end
        S_GO: begin
          tries <= tries + 1'b1;
          state <= S_WAIT;
        end
        S_WAIT: begin
          if (train_done) begin
            if (cr_ok && eq_ok) begin
              pass  <= 1'b1;
              done  <= 1'b1;
              state <= S_FIN;
            end else if (give_up || tries == TRY_W'(MAX_TRIES)) begin
              done  <= 1'b1;
              state <= S_FIN;
            end else begin
              link_rate <= nxt_rate;
              lane_cnt  <= nxt_lanes;
              state     <= S_RST;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/link_fallback_chk.sv
module link_fallback_chk #(
  parameter int RATE_W    = 8,
  parameter int LANE_W    = 3,
  parameter int MAX_LANES = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              train_done,
  input logic [RATE_W-1:0] link_rate,
  input logic [LANE_W-1:0] lane_cnt,
  input logic              phy_reset,
  input logic              train_go,
  input logic              busy,
  input logic              done,
  input logic              pass
);
  p_rst_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    phy_reset |=> !phy_reset);
  p_go_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    train_go |=> !train_go);
  p_settle_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    phy_reset |=> !train_go);
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !train_done) |=> ($stable(link_rate) && $stable(lane_cnt)));
  p_lane_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (lane_cnt <= LANE_W'(MAX_LANES)));
  p_pass_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> done);
  p_done_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(train_done));
  p_quiet_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!phy_reset && !train_go));
endmodule

bind link_fallback_ctrl link_fallback_chk #(
  .RATE_W(RATE_W), .LANE_W(LANE_W), .MAX_LANES(MAX_LANES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .train_done(train_done), .link_rate(link_rate),
  .lane_cnt(lane_cnt), .phy_reset(phy_reset), .train_go(train_go),
  .busy(busy), .done(done), .pass(pass)
);

// File: tb/link_fallback_ctrl_test.sv
module link_fallback_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 5;
  localparam int TRIES      = 6;

  logic clk = 0, rst_n = 0, start = 0, train_done = 0, cr_ok = 0, eq_ok = 0, cap_ssc = 0;
  logic [7:0] cap_rate = 0, sys_max_rate = 0;
  logic [4:0] cap_lane_field = 0;
  logic [7:0] link_rate;
  logic [2:0] lane_cnt;
  logic phy_reset, train_go, ssc_en, busy, done, pass;

  int n_tests = 0, n_fail = 0, cyc = 0;
  int m_rate = 0, m_lanes = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_fallback_ctrl #(.SETTLE_CYCLES(SETTLE), .MAX_TRIES(TRIES)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cap_rate(cap_rate),
    .cap_lane_field(cap_lane_field), .sys_max_rate(sys_max_rate), .cap_ssc(cap_ssc),
    .train_done(train_done), .cr_ok(cr_ok), .eq_ok(eq_ok), .link_rate(link_rate),
    .lane_cnt(lane_cnt), .phy_reset(phy_reset), .train_go(train_go), .ssc_en(ssc_en),
    .busy(busy), .done(done), .pass(pass));

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // per-clock comparison of the held settings against the model (R3)
  always @(negedge clk) begin
    if (rst_n && busy) begin
      check(int'(link_rate) == m_rate, "R3", "held rate", link_rate, m_rate);
      check(int'(lane_cnt) == m_lanes, "R3", "held lanes", lane_cnt, m_lanes);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_fail++;
      $display("FAIL R2 watchdog: cycles %0d expected < %0d", cyc, 50000);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // behavioural fallback rule taken from R4..R7
  function automatic void ladder(input int r, input int l, input int top,
                                 input bit cr, input bit eq,
                                 output int nr, output int nl, output bit bad);
    nr = r; nl = l; bad = 0;
    if (!cr) begin
      if (r == 'h06) begin nl = l / 2; nr = top; bad = (nl == 0); end
      else if (r == 'h0A) nr = 'h06;
      else if (r == 'h14) nr = 'h0A;
      else if (r == 'h1E) nr = 'h14;
      else bad = 1;
    end else if (!eq) begin
      if (l == 4) nl = 2;
      else if (l == 2) nl = 1;
      else bad = 1;
    end
  endfunction

  task automatic run_case(input string req, input logic [7:0] c1, input logic [4:0] c2,
                          input logic [7:0] sm, input bit ssc,
                          input logic [7:0] crv, input logic [7:0] eqv, input bit poke,
                          input int exp_att, input bit exp_pass);
    int top, tries, gap, nr, nl;
    bit fin, bad, got_pass;
    @(negedge clk);
    cap_rate = c1; cap_lane_field = c2; sys_max_rate = sm; cap_ssc = ssc; start = 1;
    top = (c1 < sm) ? c1 : sm;
    m_rate = top;
    m_lanes = (c2 >= 4) ? 4 : c2;
    @(negedge clk);
    start = 0;
    check(busy == 1 && done == 0, req, "busy after start", busy, 1);
    check(int'(link_rate) == m_rate && int'(lane_cnt) == m_lanes, "R1", "start clamp",
          {link_rate, 5'b0, lane_cnt}, {m_rate[7:0], 5'b0, m_lanes[2:0]});
    tries = 0; fin = 0; got_pass = 0;
    while (!fin) begin
      check(phy_reset == 1, "R2", "phy reset pulse", phy_reset, 1);
      if (tries == 0) check(ssc_en == ssc, "R2", "spread-spectrum", ssc_en, ssc);
      gap = 0;
      do begin
        @(negedge clk);
        gap++;
        if (poke && tries == 0 && gap == 2) begin
          start = 1; cap_rate = 8'h06; cap_lane_field = 5'd1;
        end else start = 0;
      end while (!train_go && gap < SETTLE + 4);
      check(gap == SETTLE + 1, "R2", "settle gap", gap, SETTLE + 1);
      check(int'(link_rate) == m_rate, poke ? "R11" : "R4", "attempt rate", link_rate, m_rate);
      check(int'(lane_cnt) == m_lanes, poke ? "R11" : "R5", "attempt lanes", lane_cnt, m_lanes);
      @(negedge clk);
      train_done = 1; cr_ok = crv[tries]; eq_ok = eqv[tries];
      @(posedge clk);
      tries++;
      if (cr_ok && eq_ok) begin
        fin = 1; got_pass = 1;
      end else begin
        ladder(m_rate, m_lanes, top, cr_ok, eq_ok, nr, nl, bad);
        if (bad || tries == TRIES) fin = 1;
        else begin m_rate = nr; m_lanes = nl; end
      end
      @(negedge clk);
      train_done = 0; cr_ok = 0; eq_ok = 0;
      if (fin) check(done == 1 && busy == 0, "R10", "finished", done, 1);
    end
    check(tries == exp_att, "R9", "attempt count", tries, exp_att);
    check(got_pass == exp_pass && pass == exp_pass, req, "result", pass, exp_pass);
    check(int'(link_rate) == m_rate, req, "final rate", link_rate, m_rate);
    check(int'(lane_cnt) == m_lanes, req, "final lanes", lane_cnt, m_lanes);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0 && pass == 0, "R12", "reset outputs", {busy, done, pass}, 0);
    check(phy_reset == 0 && train_go == 0, "R12", "reset pulses", {phy_reset, train_go}, 0);
    rst_n = 1;
    @(negedge clk);
    check(busy == 0 && done == 0, "R12", "idle after reset", {busy, done}, 0);
    run_case("R8",  8'h14, 5'h04, 8'h1E, 1, 8'hFF, 8'hFF, 0, 1, 1);
    run_case("R1",  8'h1E, 5'h1F, 8'h14, 0, 8'hFF, 8'hFF, 0, 1, 1);
    run_case("R9",  8'h1E, 5'h04, 8'h1E, 0, 8'h00, 8'hFF, 0, 6, 0);
    run_case("R7",  8'h14, 5'h04, 8'h1E, 1, 8'hFF, 8'h00, 0, 3, 0);
    run_case("R8",  8'h0A, 5'h02, 8'h1E, 0, 8'hFE, 8'hFD, 0, 3, 1);
    run_case("R5",  8'h06, 5'h01, 8'h1E, 0, 8'h00, 8'hFF, 0, 1, 0);
    run_case("R6",  8'h19, 5'h04, 8'h1E, 0, 8'h00, 8'hFF, 0, 1, 0);
    run_case("R7",  8'h14, 5'h03, 8'h1E, 0, 8'hFF, 8'h00, 0, 1, 0);
    run_case("R5",  8'h06, 5'h04, 8'h0A, 1, 8'h00, 8'hFF, 0, 3, 0);
    run_case("R11", 8'h14, 5'h04, 8'h1E, 1, 8'hFE, 8'hFF, 1, 2, 1);
    @(negedge clk);
    check(done == 1 && busy == 0, "R10", "done held", done, 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule